// File: doc/BRIEF.md
# Quarter-Wave Table Sine/Cosine Synthesizer

This block generates a sampled sine wave, and optionally a cosine wave, whose frequency is set by a tuning word. A 20-bit phase register adds the active tuning word on every clock and wraps modulo 2^20. One output period therefore spans 2^20 / word samples, and the frequency step is fclk / 2^20. Only the upper 12 phase bits are used to look up the amplitude. The lower bits are dropped, and the spurs this causes are accepted.

The amplitude table covers a single quadrant of 1024 magnitudes and is computed at elaboration. The two top phase bits choose the quadrant. They mirror the table address and flip the sign, which rebuilds the full wave. A new tuning word is first captured into a holding register and then copied into the active register. The phase register is never cleared when this happens, so a frequency hop keeps the phase continuous.

Top module: `dds_quarter_synth`

## Requirements
- R1: While `rst_n` is low and on the first clock after its release, `amp_valid` is 0 and both amplitude outputs are 0. Reset sets the phase to 0 and the active word to 0. Until the first load, the outputs therefore stay constant at the amplitudes for phase 0 (sine) and phase 1024 (cosine).
- R2: The phase register is 20 bits wide, adds the active word once per clock and wraps modulo 2^20. A word of 4096 repeats the output every 256 samples. A word above 2^19 runs the phase backwards.
- R3: Only phase bits [19:8] form the 12-bit truncated phase p. A word below 256 moves p by at most one step per clock.
- R4: `sin_amp` equals the two's-complement value round(2047 * sin(2*pi*(p + 0.5) / 4096)). Halves round away from zero.
- R5: p[11:10] is the quadrant. Quadrants 01 and 11 address the table with the complement of p[9:0]. Quadrants 10 and 11 negate the magnitude, so phase p + 2048 gives exactly the negated amplitude of p.
- R6: The amplitude shown after clock k belongs to the phase value held before clock k-1, a two-clock latency. `amp_valid` rises on the second clock after reset release and stays high until the next reset.
- R7: A word presented with `fcw_load` high on clock k is first added on clock k+2. Loads on consecutive clocks are each applied for one clock, in order.
- R8: A load never alters the phase register itself. The phase after a hop continues from the value reached before it.
- R9: `cos_amp` follows the rule of R4 for phase (p + 1024) mod 4096, with the same latency.
- R10: While valid, neither amplitude output ever takes the value -2048.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fcw_load | input | 1 | Strobe that captures `fcw_data` into the holding register |
| fcw_data | input | 20 | Tuning word (phase increment per clock) |
| sin_amp | output | 12 | Signed sine amplitude |
| cos_amp | output | 12 | Signed cosine amplitude |
| amp_valid | output | 1 | High once the two-stage amplitude pipeline has filled |

## Verification
A tuning-word load can land on the same clock as a phase wrap-around. Loads can also arrive on consecutive clocks, while the previous word is still waiting to move from the holding register to the active register. The bench sets a half-scale word, so the phase wraps every other clock, and loads a new word in the middle of that. It also issues back-to-back loads during an ongoing ramp. Every clock, both amplitudes are compared with a behavioural model that keeps its own phase, holding word and pending flag. Any lost, doubled or reordered word, and any reset of the phase, shows up as an amplitude mismatch on the following clocks.

// File: rtl/dds_pkg.sv
// Shared types and elaboration-time helpers for the quarter-wave synthesizer.
// Assumes the table is evaluated only at elaboration (constant function).
package dds_pkg;

    // Quadrant steering decoded from the two top truncated-phase bits.
    typedef struct packed {
        logic mirror;   // address runs backwards through the quadrant
        logic negate;   // magnitude is subtracted from zero
    } quad_ctl_t;

    // Magnitude of one quarter-table entry, sampled at the middle of its step.
    function automatic int quarter_sine(input int idx, input int depth, input int peak);
        real ang;
        real mag;
        ang = 6.283185307179586 * (real'(idx) + 0.5) / (4.0 * real'(depth));
        mag = real'(peak) * $sin(ang);
        return $rtoi(mag + 0.5);
    endfunction

    // Map quadrant number to mirror/negate controls.
    function automatic quad_ctl_t decode_quad(input logic [1:0] quad);
        quad_ctl_t ctl;
        ctl.mirror = quad[0];
        ctl.negate = quad[1];
        return ctl;
    endfunction

endpackage

// File: rtl/dds_phase_acc.sv
// Phase accumulator with a two-stage tuning word path (holding -> active).
// A word captured on clock k becomes active on k+1 and is first added on k+2.
// The phase register is never cleared by a load, only by reset.
// Only the top PH_W bits leave the module; the rest are truncated.
module dds_phase_acc #(
    parameter int ACC_W = 20,
    parameter int PH_W  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [ACC_W-1:0] word,
    output logic [PH_W-1:0]  phase_top
);

    logic [ACC_W-1:0] hold_q;
    logic [ACC_W-1:0] act_q;
    logic [ACC_W-1:0] acc_q;
    logic             pend_q;

    // Capture a newly presented tuning word into the holding register.
    always_ff @(posedge clk) begin
        if (!rst_n)     hold_q <= '0;
        else if (load)  hold_q <= word;
    end

    // Remember that the holding register carries a word not yet active.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= load;
    end

    // Transfer the pending word into the active register.
    always_ff @(posedge clk) begin
        if (!rst_n)      act_q <= '0;
        else if (pend_q) act_q <= hold_q;
    end

    // Advance the phase by the active word, wrapping modulo 2^ACC_W.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_q + act_q;
    end

    assign phase_top = acc_q[ACC_W-1 -: PH_W];

endmodule

// File: rtl/dds_quarter_rom.sv
// Quarter-wave magnitude table with a registered read port.
// Contents are computed at elaboration; no file is read.
// Entry i holds round(PEAK * sin(2*pi*(i+0.5)/(4*DEPTH))).
module dds_quarter_rom #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int PEAK  = (1 << DATA_W) - 1;

    logic [DATA_W-1:0] tbl [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_tbl
        localparam int VAL = dds_pkg::quarter_sine(i, DEPTH, PEAK);
        assign tbl[i] = DATA_W'(VAL);
    end

    // Registered table read (first pipeline stage).
    always_ff @(posedge clk) begin
        if (!rst_n) data <= '0;
        else        data <= tbl[addr];
    end

endmodule

// File: rtl/dds_amp_path.sv
// Truncated phase to signed amplitude: folds the address by quadrant,
// reads the quarter table (stage 1) and applies the sign (stage 2).
// Fixed latency of two clocks from phase to amplitude.
module dds_amp_path #(
    parameter int PH_W  = 12,
    parameter int AMP_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [PH_W-1:0]         phase,
    output logic signed [AMP_W-1:0] amp
);

    localparam int ADDR_W = PH_W - 2;
    localparam int MAG_W  = AMP_W - 1;

    dds_pkg::quad_ctl_t      ctl;
    logic [ADDR_W-1:0]       lo;
    logic [ADDR_W-1:0]       addr;
    logic [MAG_W-1:0]        mag;
    logic                    neg_q;
    logic signed [AMP_W-1:0] mag_s;

    // Decode quadrant and fold the address for mirrored quadrants.
    always_comb begin
        ctl  = dds_pkg::decode_quad(phase[PH_W-1 -: 2]);
        lo   = phase[ADDR_W-1:0];
        addr = ctl.mirror ? ~lo : lo;
    end

    dds_quarter_rom #(
        .ADDR_W (ADDR_W),
        .DATA_W (MAG_W)
    ) u_rom (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr),
        .data  (mag)
    );

    // Carry the sign decision alongside the table read.
    always_ff @(posedge clk) begin
        if (!rst_n) neg_q <= 1'b0;
        else        neg_q <= ctl.negate;
    end

    assign mag_s = signed'({1'b0, mag});

    // Apply the sign and register the amplitude (second pipeline stage).
    always_ff @(posedge clk) begin
        if (!rst_n) amp <= '0;
        else        amp <= neg_q ? -mag_s : mag_s;
    end

endmodule

// File: rtl/dds_quarter_synth.sv
// Top of the quarter-wave synthesizer: phase accumulator, sine path and an
// optional cosine path offset by a quarter turn, plus the pipeline-fill flag.
// Assumes PH_W >= 3 and AMP_W >= 2; reset is synchronous and active low.
module dds_quarter_synth #(
    parameter int ACC_W   = 20,
    parameter int PH_W    = 12,
    parameter int AMP_W   = 12,
    parameter bit HAS_COS = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fcw_load,
    input  logic [ACC_W-1:0]        fcw_data,
    output logic signed [AMP_W-1:0] sin_amp,
    output logic signed [AMP_W-1:0] cos_amp,
    output logic                    amp_valid
);

    localparam int PIPE_D = 2;
    localparam logic [PH_W-1:0] QUARTER = PH_W'(1) << (PH_W - 2);

    logic [PH_W-1:0]   ph_sin;
    logic [PIPE_D-1:0] fill_q;

    dds_phase_acc #(
        .ACC_W (ACC_W),
        .PH_W  (PH_W)
    ) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (fcw_load),
        .word      (fcw_data),
        .phase_top (ph_sin)
    );

    dds_amp_path #(
        .PH_W  (PH_W),
        .AMP_W (AMP_W)
    ) u_sin (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (ph_sin),
        .amp   (sin_amp)
    );

    if (HAS_COS) begin : g_cos
        logic [PH_W-1:0] ph_cos;
        assign ph_cos = ph_sin + QUARTER;
        dds_amp_path #(
            .PH_W  (PH_W),
            .AMP_W (AMP_W)
        ) u_cos (
            .clk   (clk),
            .rst_n (rst_n),
            .phase (ph_cos),
            .amp   (cos_amp)
        );
    end else begin : g_no_cos
        assign cos_amp = '0;
    end

    // Track pipeline fill so the valid flag rises once real data arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) fill_q <= '0;
        else        fill_q <= {fill_q[PIPE_D-2:0], 1'b1};
    end

    assign amp_valid = fill_q[PIPE_D-1];

endmodule

// File: rtl/dds_synth_checker.sv
// Temporal checks on the synthesizer ports; attached by bind below.
module dds_synth_checker #(
    parameter int AMP_W = 12
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    fcw_load,
    input logic signed [AMP_W-1:0] sin_amp,
    input logic                    amp_valid
);

    logic [1:0] cyc_q;
    logic       seen_q;

    // Count clocks since reset release, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)             cyc_q <= 2'd0;
        else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
    end

    // Note whether any tuning word has been loaded since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        seen_q <= 1'b0;
        else if (fcw_load) seen_q <= 1'b1;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_q == 2'd0 |-> (!amp_valid && sin_amp == '0));                          // R1
    AST_IDLE_CONSTANT: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_q && cyc_q == 2'd3) |-> $stable(sin_amp));                          // R1
    AST_VALID_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_q != 2'd0 |-> (amp_valid == (cyc_q >= 2'd2)));                         // R6
    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        amp_valid |=> amp_valid);                                                  // R6
    AST_AMP_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        amp_valid |-> (sin_amp != {1'b1, {(AMP_W-1){1'b0}}}));                     // R10

endmodule

bind dds_quarter_synth dds_synth_checker #(.AMP_W(AMP_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fcw_load  (fcw_load),
    .sin_amp   (sin_amp),
    .amp_valid (amp_valid)
);

// File: tb/test_dds_quarter_synth.sv
`timescale 1ns/1ps
module test_dds_quarter_synth;

    localparam int ACC_W = 20;
    localparam int AMP_W = 12;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    fcw_load = 1'b0;
    logic [ACC_W-1:0]        fcw_data = '0;
    logic signed [AMP_W-1:0] sin_amp;
    logic signed [AMP_W-1:0] cos_amp;
    logic                    amp_valid;

    int    checks = 0;
    int    fails = 0;
    bit    done = 0;
    bit    live = 0;
    string tag = "R4";

    // behavioural reference state
    int unsigned m_acc, m_act, m_hold;
    bit          m_pend;
    int          m_p1, m_p2, m_fill;

    always #2.5 clk = ~clk;

    dds_quarter_synth i_dds_quarter_synth (
        .clk(clk), .rst_n(rst_n), .fcw_load(fcw_load), .fcw_data(fcw_data),
        .sin_amp(sin_amp), .cos_amp(cos_amp), .amp_valid(amp_valid)
    );

    function automatic int ref_amp(input int p);
        real v;
        v = 2047.0 * $sin(6.283185307179586 * (real'(p % 4096) + 0.5) / 4096.0);
        if (v >= 0.0) return $rtoi(v + 0.5);
        return -$rtoi(-v + 0.5);
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference model: advances on the same edge as the design.
    always @(posedge clk) begin
        int unsigned n_act;
        if (!rst_n) begin
            m_acc = 0; m_act = 0; m_hold = 0; m_pend = 0;
            m_p1 = 0; m_p2 = 0; m_fill = 0;
        end else begin
            m_p2 = m_p1;
            m_p1 = int'(m_acc >> 8);
            if (m_fill < 2) m_fill++;
            n_act = m_pend ? m_hold : m_act;
            m_acc = (m_acc + m_act) % (1 << ACC_W);
            m_act = n_act;
            if (fcw_load) m_hold = fcw_data;
            m_pend = fcw_load;
        end
    end

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        if (live && rst_n) begin
            check("R6", "valid", int'(amp_valid), (m_fill >= 2) ? 1 : 0);
            if (m_fill >= 2) begin
                check(tag, "sin", int'(sin_amp), ref_amp(m_p2));
                check("R9", "cos", int'(cos_amp), ref_amp(m_p2 + 1024));
                check("R10", "floor", (int'(sin_amp) == -2048 || int'(cos_amp) == -2048) ? 1 : 0, 0);
            end
        end
    end

    task automatic load_word(input int unsigned w);
        @(negedge clk);
        fcw_load = 1'b1;
        fcw_data = ACC_W'(w);
        @(negedge clk);
        fcw_load = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R6 watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        int a;
        int changes;
        int prev;
        // R1: reset state
        repeat (4) @(negedge clk);
        check("R1", "valid in reset", int'(amp_valid), 0);
        check("R1", "sin in reset", int'(sin_amp), 0);
        check("R1", "cos in reset", int'(cos_amp), 0);
        rst_n = 1'b1;
        live = 1'b1;
        @(negedge clk);
        check("R1", "sin first clock", int'(sin_amp), 0);
        // R1: constant output with zero word
        tag = "R1";
        repeat (20) @(negedge clk);
        check("R1", "idle sin", int'(sin_amp), ref_amp(0));
        check("R1", "idle cos", int'(cos_amp), ref_amp(1024));

        // R2 / R5: period 256 and half-period negation
        tag = "R4";
        load_word(4096);
        repeat (300) @(negedge clk);
        a = int'(sin_amp);
        repeat (128) @(negedge clk);
        check("R5", "half period negates", int'(sin_amp), -a);
        repeat (128) @(negedge clk);
        check("R2", "full period repeats", int'(sin_amp), a);

        // R2: backwards phase
        tag = "R2";
        load_word((1 << ACC_W) - 4096);
        repeat (300) @(negedge clk);

        // R3: small word, truncated phase moves slowly
        tag = "R3";
        load_word(100);
        repeat (10) @(negedge clk);
        changes = 0;
        prev = int'(sin_amp);
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            if (int'(sin_amp) != prev) changes++;
            prev = int'(sin_amp);
        end
        check("R3", "changes over 256 clocks within 101", (changes <= 101) ? 1 : 0, 1);

        // R8: mid-run hop keeps phase
        tag = "R8";
        load_word(5000);
        repeat (77) @(negedge clk);
        load_word(70000);
        repeat (200) @(negedge clk);

        // R7: back-to-back loads and a load during wrap-around
        tag = "R7";
        @(negedge clk);
        fcw_load = 1'b1; fcw_data = ACC_W'(3000);
        @(negedge clk);
        fcw_data = ACC_W'(9000);
        @(negedge clk);
        fcw_load = 1'b0;
        repeat (100) @(negedge clk);
        load_word(1 << (ACC_W - 1));
        repeat (5) @(negedge clk);
        load_word(12345);
        repeat (100) @(negedge clk);

        // R5: sweep all quadrants with a coarse word
        tag = "R5";
        load_word(3 << 16);
        repeat (200) @(negedge clk);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule